// File: doc/BRIEF.md
# BCD Calendar Clock with 12/24-Hour Mode

This block keeps wall-clock time and a calendar as packed BCD bytes: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A one-cycle pulse on `tick_i` marks each elapsed second. While the run bit in the control byte is set, each such pulse moves the time on by one second, and carries pass up through the whole calendar. That includes month lengths and leap Februaries.

The hours byte holds its own format. Its top bit chooses 12-hour coding, which has a PM flag, or plain 24-hour coding. The counter steps in whichever coding the byte currently holds. Software reads any byte through a combinational read port and writes any byte through a single-cycle write port. To load a new time, it clears the run bit, writes the fields and sets the run bit again. Three alarm bytes for seconds, minutes and hours are compared against the running time, and the result drives a level match output.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset the bytes read as follows. Seconds 0x00, minutes 0x00, hours 0x00 (24-hour midnight), weekday 0x01, date 0x01, month 0x01, year 0x00. Alarm seconds and minutes read 0x00, alarm hours read 0x3F (a value that never matches), control reads 0x00, and `alarm_o` is low.
- R2: The byte addresses are: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year, 7 alarm seconds, 8 alarm minutes, 9 alarm hours, 10 control (bit 0 is the run bit). Writes keep only the significant bits: seconds and minutes keep [6:0], both hour bytes clear bit 6, weekday keeps [2:0], date keeps [5:0] and month keeps [4:0]. Addresses 11 to 15 read 0x00 and ignore writes. `rd_data_o` shows the byte at `rd_addr_i` in the same cycle.
- R3: With the run bit set, a cycle with `tick_i` high and no write adds one BCD second. Seconds step from 0x59 to 0x00 and carry into minutes. Minutes step from 0x59 to 0x00 and carry into hours.
- R4: With hours bit 7 clear, the hour is BCD in bits [5:0] and steps from 0x23 to 0x00, carrying one day.
- R5: With hours bit 7 set, bit 5 is PM and bits [4:0] hold the BCD hour from 1 to 12. The hour 11 steps to 12 and toggles PM. The hour 12 steps to 1 and keeps PM. Only 11 PM to 12 AM carries a day, so midnight reads 0x92 and noon reads 0xB2.
- R6: A day carry steps the weekday from 1 to 7 and back to 1, and steps the date. The last date is 0x30 for months 0x04, 0x06, 0x09 and 0x11, 0x31 for the other months, and 0x28 for month 0x02, or 0x29 when the year is divisible by 4. Passing the last date sets date 0x01 and steps the month. Month 0x12 wraps to 0x01 and steps the year. The year steps from 0x99 to 0x00.
- R7: While the run bit is clear, ticks change no time byte, and writes still load.
- R8: `alarm_o` is high exactly while the seconds, minutes and hours bytes equal the three alarm bytes.
- R9: A write in the same cycle as a tick takes effect, and that tick is dropped for every field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-second pulse, one cycle wide |
| wr_en_i | input | 1 | Byte write strobe |
| wr_addr_i | input | 4 | Write byte address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 4 | Read byte address |
| rd_data_o | output | 8 | Byte at `rd_addr_i` |
| alarm_o | output | 1 | Alarm match level |

## Verification
The hardest states to reach are the calendar boundaries. At one tick per second, a day takes 86,400 ticks, and a leap February or a century wrap would never arrive in a bounded run. The stimulus therefore loads the time to one second before each boundary and then issues a single tick. The boundaries covered are the end of a 30-day month, February in leap and plain years, December 31 of year 99, and the 11-to-12 and 12-to-1 transitions in 12-hour coding. A long random phase follows. It mixes loads biased toward 59 seconds, 59 minutes and the last hour with dense ticks, run toggles and ticks that coincide with writes. A reference model runs alongside it, and the read address sweeps every byte, including the unmapped ones.

// File: rtl/calclk_pkg.sv
package calclk_pkg;

  localparam int REG_AW = 4;
  localparam int NUM_REGS = 16;

  localparam logic [REG_AW-1:0] ADR_SEC   = 4'd0;
  localparam logic [REG_AW-1:0] ADR_MIN   = 4'd1;
  localparam logic [REG_AW-1:0] ADR_HOUR  = 4'd2;
  localparam logic [REG_AW-1:0] ADR_WDAY  = 4'd3;
  localparam logic [REG_AW-1:0] ADR_DATE  = 4'd4;
  localparam logic [REG_AW-1:0] ADR_MON   = 4'd5;
  localparam logic [REG_AW-1:0] ADR_YEAR  = 4'd6;
  localparam logic [REG_AW-1:0] ADR_ASEC  = 4'd7;
  localparam logic [REG_AW-1:0] ADR_AMIN  = 4'd8;
  localparam logic [REG_AW-1:0] ADR_AHOUR = 4'd9;
  localparam logic [REG_AW-1:0] ADR_CTRL  = 4'd10;

  localparam logic [7:0] HOUR_KEEP = 8'hBF;

  // Adds one to a two-digit packed BCD value.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // Returns the last day of a month, in BCD. The leap test uses the year
  // digits only: an even tens digit takes ones 0/4/8, an odd one takes 2/6.
  function automatic logic [7:0] month_last_day(input logic [7:0] mon,
                                                input logic [7:0] yr);
    logic leap;
    logic [7:0] r;
    if (yr[4]) leap = (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    else       leap = (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    case (mon)
      8'h02:                      r = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/calclk_bcd_counter.sv
module calclk_bcd_counter
  import calclk_pkg::*;
#(
  parameter int         WIDTH   = 7,
  parameter logic [7:0] RST_VAL = 8'h00,
  parameter logic [7:0] MIN_VAL = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_i,
  input  logic [7:0] ld_val_i,
  input  logic       inc_i,
  input  logic [7:0] max_i,
  output logic [7:0] val_o,
  output logic       wrap_o
);

  logic [WIDTH-1:0] val_q;
  logic [WIDTH-1:0] val_d;
  logic             at_max;
  logic             cnt_en;

  assign val_o  = 8'(val_q);
  assign at_max = (val_o == max_i);
  assign wrap_o = inc_i & ~ld_i & at_max;
  assign cnt_en = ld_i | inc_i;

  always_comb begin
    val_d = val_q;
    if (ld_i)       val_d = WIDTH'(ld_val_i);
    else if (inc_i) val_d = at_max ? WIDTH'(MIN_VAL) : WIDTH'(bcd_inc(val_o));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= WIDTH'(RST_VAL);
    else if (cnt_en) val_q <= val_d;
  end

  // R3
  wrap_to_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !ld_i && at_max) |=> (val_o == MIN_VAL));

  // R3
  bcd_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !ld_i && (val_o[3:0] <= 4'd9)) |=> (val_o[3:0] <= 4'd9));

endmodule

// File: rtl/calclk_hour_counter.sv
module calclk_hour_counter
  import calclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_i,
  input  logic [7:0] ld_val_i,
  input  logic       inc_i,
  output logic [7:0] val_o,
  output logic       day_o
);

  logic [7:0] val_q;
  logic [7:0] val_d;
  logic [7:0] inc24;
  logic [7:0] inc12;
  logic       mode12;
  logic       pm;
  logic       roll24;
  logic       pm_wrap;
  logic       cnt_en;

  assign mode12  = val_q[7];
  assign pm      = val_q[5];
  assign inc24   = bcd_inc({2'b00, val_q[5:0]});
  assign inc12   = bcd_inc({3'b000, val_q[4:0]});
  assign roll24  = !mode12 && (val_q[5:0] == 6'h23);
  assign pm_wrap = mode12 && pm && (val_q[4:0] == 5'h11);
  assign day_o   = inc_i & ~ld_i & (roll24 | pm_wrap);
  assign cnt_en  = ld_i | inc_i;
  assign val_o   = val_q;

  always_comb begin
    val_d = val_q;
    if (ld_i) begin
      val_d = ld_val_i & HOUR_KEEP;
    end else if (inc_i) begin
      if (!mode12) begin
        val_d = roll24 ? 8'h00 : (inc24 & 8'h3F);
      end else if (val_q[4:0] == 5'h11) begin
        val_d = {2'b10, ~pm, 5'h12};
      end else if (val_q[4:0] == 5'h12) begin
        val_d = {2'b10, pm, 5'h01};
      end else begin
        val_d = {2'b10, pm, 5'h00} | (inc12 & 8'h1F);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= 8'h00;
    else if (cnt_en) val_q <= val_d;
  end

  // R4
  h24_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !ld_i && !val_q[7] && (val_q[5:0] == 6'h23)) |=> (val_q == 8'h00));

  // R5
  noon_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !ld_i && val_q[7] && (val_q[4:0] == 5'h11))
    |=> ((val_q[5] != $past(val_q[5])) && (val_q[4:0] == 5'h12)));

  // R5
  twelve_to_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !ld_i && val_q[7] && (val_q[4:0] == 5'h12))
    |=> ($stable(val_q[5]) && (val_q[4:0] == 5'h01)));

endmodule

// File: rtl/calclk_alarm.sv
module calclk_alarm
  import calclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_sec_i,
  input  logic       ld_min_i,
  input  logic       ld_hour_i,
  input  logic [7:0] wdata_i,
  input  logic [7:0] cur_sec_i,
  input  logic [7:0] cur_min_i,
  input  logic [7:0] cur_hour_i,
  output logic [7:0] asec_o,
  output logic [7:0] amin_o,
  output logic [7:0] ahour_o,
  output logic       match_o
);

  logic [6:0] asec_q;
  logic [6:0] amin_q;
  logic [7:0] ahour_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        asec_q <= 7'h00;
    else if (ld_sec_i) asec_q <= wdata_i[6:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        amin_q <= 7'h00;
    else if (ld_min_i) amin_q <= wdata_i[6:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ahour_q <= 8'h3F;
    else if (ld_hour_i) ahour_q <= wdata_i & HOUR_KEEP;
  end

  assign asec_o  = {1'b0, asec_q};
  assign amin_o  = {1'b0, amin_q};
  assign ahour_o = ahour_q;
  assign match_o = (cur_sec_i == asec_o) && (cur_min_i == amin_o) &&
                   (cur_hour_i == ahour_q);

endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
  import calclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [REG_AW-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              alarm_o
);

  logic [1:0]          rst_pipe;
  logic                srst_n;
  logic [NUM_REGS-1:0] ld;
  logic                run_q;
  logic                tick_ok;

  logic [7:0] sec_v, min_v, hour_v, wday_v, date_v, mon_v, year_v;
  logic [7:0] asec_v, amin_v, ahour_v;
  logic [7:0] date_max;
  logic       sec_wrap, min_wrap, day_carry, wday_wrap, date_wrap, mon_wrap, yr_wrap;

  // Reset asserts at once and leaves after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_wdec
    assign ld[g] = wr_en_i && (wr_addr_i == REG_AW'(g));
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)        run_q <= 1'b0;
    else if (ld[ADR_CTRL]) run_q <= wr_data_i[0];
  end

  // A write cycle drops the tick for every field.
  assign tick_ok  = tick_i & run_q & ~wr_en_i;
  assign date_max = month_last_day(mon_v, year_v);

  calclk_bcd_counter #(.WIDTH(7), .RST_VAL(8'h00), .MIN_VAL(8'h00)) u_sec (
    .clk(clk), .rst_n(srst_n), .ld_i(ld[ADR_SEC]), .ld_val_i(wr_data_i),
    .inc_i(tick_ok), .max_i(8'h59), .val_o(sec_v), .wrap_o(sec_wrap));

  calclk_bcd_counter #(.WIDTH(7), .RST_VAL(8'h00), .MIN_VAL(8'h00)) u_min (
    .clk(clk), .rst_n(srst_n), .ld_i(ld[ADR_MIN]), .ld_val_i(wr_data_i),
    .inc_i(sec_wrap), .max_i(8'h59), .val_o(min_v), .wrap_o(min_wrap));

  calclk_hour_counter u_hour (
    .clk(clk), .rst_n(srst_n), .ld_i(ld[ADR_HOUR]), .ld_val_i(wr_data_i),
    .inc_i(min_wrap), .val_o(hour_v), .day_o(day_carry));

  calclk_bcd_counter #(.WIDTH(3), .RST_VAL(8'h01), .MIN_VAL(8'h01)) u_wday (
    .clk(clk), .rst_n(srst_n), .ld_i(ld[ADR_WDAY]), .ld_val_i(wr_data_i),
    .inc_i(day_carry), .max_i(8'h07), .val_o(wday_v), .wrap_o(wday_wrap));

  calclk_bcd_counter #(.WIDTH(6), .RST_VAL(8'h01), .MIN_VAL(8'h01)) u_date (
    .clk(clk), .rst_n(srst_n), .ld_i(ld[ADR_DATE]), .ld_val_i(wr_data_i),
    .inc_i(day_carry), .max_i(date_max), .val_o(date_v), .wrap_o(date_wrap));

  calclk_bcd_counter #(.WIDTH(5), .RST_VAL(8'h01), .MIN_VAL(8'h01)) u_mon (
    .clk(clk), .rst_n(srst_n), .ld_i(ld[ADR_MON]), .ld_val_i(wr_data_i),
    .inc_i(date_wrap), .max_i(8'h12), .val_o(mon_v), .wrap_o(mon_wrap));

  calclk_bcd_counter #(.WIDTH(8), .RST_VAL(8'h00), .MIN_VAL(8'h00)) u_year (
    .clk(clk), .rst_n(srst_n), .ld_i(ld[ADR_YEAR]), .ld_val_i(wr_data_i),
    .inc_i(mon_wrap), .max_i(8'h99), .val_o(year_v), .wrap_o(yr_wrap));

  calclk_alarm u_alarm (
    .clk(clk), .rst_n(srst_n), .ld_sec_i(ld[ADR_ASEC]), .ld_min_i(ld[ADR_AMIN]),
    .ld_hour_i(ld[ADR_AHOUR]), .wdata_i(wr_data_i), .cur_sec_i(sec_v),
    .cur_min_i(min_v), .cur_hour_i(hour_v), .asec_o(asec_v), .amin_o(amin_v),
    .ahour_o(ahour_v), .match_o(alarm_o));

  always_comb begin
    case (rd_addr_i)
      ADR_SEC:   rd_data_o = sec_v;
      ADR_MIN:   rd_data_o = min_v;
      ADR_HOUR:  rd_data_o = hour_v;
      ADR_WDAY:  rd_data_o = wday_v;
      ADR_DATE:  rd_data_o = date_v;
      ADR_MON:   rd_data_o = mon_v;
      ADR_YEAR:  rd_data_o = year_v;
      ADR_ASEC:  rd_data_o = asec_v;
      ADR_AMIN:  rd_data_o = amin_v;
      ADR_AHOUR: rd_data_o = ahour_v;
      ADR_CTRL:  rd_data_o = {7'd0, run_q};
      default:   rd_data_o = 8'h00;
    endcase
  end

  // R7
  frozen_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!run_q && !wr_en_i) |=> ($stable(sec_v) && $stable(min_v) &&
                              $stable(hour_v) && $stable(date_v)));

  // R9
  write_drops_tick_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (tick_i && wr_en_i && (wr_addr_i != ADR_SEC)) |=> $stable(sec_v));

  // R6
  wday_wrap_chk: assert property (@(posedge clk) disable iff (!srst_n)
    wday_wrap |=> (wday_v == 8'h01));

  // R6
  century_wrap_chk: assert property (@(posedge clk) disable iff (!srst_n)
    yr_wrap |=> ((year_v == 8'h00) && (mon_v == 8'h01) && (date_v == 8'h01)));

endmodule

// File: tb/bcd_calendar_clock_tb.sv
`timescale 1ns/1ps
module bcd_calendar_clock_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       wr_en;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic [3:0] rd_addr;
  logic [7:0] rd_data;
  logic       alarm;

  always #2.5 clk = ~clk;

  bcd_calendar_clock u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .alarm_o(alarm));

  int compared = 0;
  int mismatched = 0;
  bit hold = 0;
  logic [7:0] last_rd;
  logic       last_alarm;

  // Reference model state: plain integers.
  int m_sec, m_min, m_h24, m_wday, m_date, m_mon, m_year;
  bit m_12, m_run;
  logic [7:0] m_asec, m_amin, m_ahour;

  function automatic logic [7:0] bcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic int unbcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int dim(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] hour_byte();
    int h12;
    if (!m_12) return bcd(m_h24);
    h12 = (m_h24 % 12 == 0) ? 12 : m_h24 % 12;
    return 8'h80 | ((m_h24 >= 12) ? 8'h20 : 8'h00) | bcd(h12);
  endfunction

  function automatic logic [7:0] model_byte(input logic [3:0] a);
    case (a)
      4'd0:  return bcd(m_sec);
      4'd1:  return bcd(m_min);
      4'd2:  return hour_byte();
      4'd3:  return bcd(m_wday);
      4'd4:  return bcd(m_date);
      4'd5:  return bcd(m_mon);
      4'd6:  return bcd(m_year);
      4'd7:  return m_asec;
      4'd8:  return m_amin;
      4'd9:  return m_ahour;
      4'd10: return {7'd0, m_run};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic model_alarm();
    return (bcd(m_sec) == m_asec) && (bcd(m_min) == m_amin) && (hour_byte() == m_ahour);
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    if (a <= 4'd1) return "R3";
    if (a == 4'd2) return m_12 ? "R5" : "R4";
    if (a <= 4'd6) return "R6";
    return "R2";
  endfunction

  task automatic model_reset();
    m_sec = 0; m_min = 0; m_h24 = 0; m_12 = 0; m_wday = 1; m_date = 1;
    m_mon = 1; m_year = 0; m_run = 0; m_asec = 8'h00; m_amin = 8'h00; m_ahour = 8'h3F;
  endtask

  task automatic model_write(input logic [3:0] a, input logic [7:0] d);
    int v;
    case (a)
      4'd0: m_sec = unbcd(d & 8'h7F);
      4'd1: m_min = unbcd(d & 8'h7F);
      4'd2: begin
        if (d[7]) begin
          m_12 = 1; v = unbcd({3'b0, d[4:0]});
          m_h24 = ((v == 12) ? 0 : v) + (d[5] ? 12 : 0);
        end else begin
          m_12 = 0; m_h24 = unbcd({2'b0, d[5:0]});
        end
      end
      4'd3: m_wday = int'(d[2:0]);
      4'd4: m_date = unbcd(d & 8'h3F);
      4'd5: m_mon = unbcd(d & 8'h1F);
      4'd6: m_year = unbcd(d);
      4'd7: m_asec = d & 8'h7F;
      4'd8: m_amin = d & 8'h7F;
      4'd9: m_ahour = d & 8'hBF;
      4'd10: m_run = d[0];
      default: ;
    endcase
  endtask

  task automatic model_tick();
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_h24++;
        if (m_h24 == 24) begin
          m_h24 = 0;
          m_wday = (m_wday == 7) ? 1 : m_wday + 1;
          m_date++;
          if (m_date > dim(m_mon, m_year)) begin
            m_date = 1; m_mon++;
            if (m_mon > 12) begin
              m_mon = 1; m_year = (m_year + 1) % 100;
            end
          end
        end
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else if (wr_en) model_write(wr_addr, wr_data);
    else if (tick && m_run) model_tick();
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s act=%02h exp=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: compare at the falling edge, then advance the read sweep.
  task automatic step();
    @(negedge clk);
    last_rd = rd_data;
    last_alarm = alarm;
    if (rst_n) begin
      chk(tag_of(rd_addr), rd_data, model_byte(rd_addr));
      chk("R8", {7'd0, alarm}, {7'd0, model_alarm()});
    end
    if (!hold) rd_addr = rd_addr + 4'd1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic t);
    wr_en = 1; wr_addr = a; wr_data = d; tick = t;
    step();
    wr_en = 0; tick = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; step();
    end
    tick = 0;
  endtask

  task automatic expect_reg(input logic [3:0] a, input logic [7:0] e, input string tag);
    hold = 1; rd_addr = a; tick = 0; wr_en = 0;
    step();
    chk(tag, last_rd, e);
    hold = 0;
  endtask

  task automatic expect_alarm(input logic e, input string tag);
    tick = 0; wr_en = 0;
    step();
    chk(tag, {7'd0, last_alarm}, {7'd0, e});
  endtask

  task automatic load_time(input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s,
                           input logic [7:0] wd, input logic [7:0] dt,
                           input logic [7:0] mo, input logic [7:0] yr);
    wr(4'd10, 8'h00, 0);
    wr(4'd2, h, 0); wr(4'd1, mi, 0); wr(4'd0, s, 0); wr(4'd3, wd, 0);
    wr(4'd4, dt, 0); wr(4'd5, mo, 0); wr(4'd6, yr, 0);
    wr(4'd10, 8'h01, 0);
  endtask

  function automatic logic [7:0] rand_val(input logic [3:0] a);
    int h;
    case (a)
      4'd0, 4'd7: return bcd(($urandom % 2) ? 50 + $urandom % 10 : $urandom % 60);
      4'd1, 4'd8: return bcd(($urandom % 2) ? 59 : $urandom % 60);
      4'd2, 4'd9: begin
        if ($urandom % 2) begin
          h = 1 + $urandom % 12;
          return 8'h80 | (($urandom % 2) ? 8'h20 : 8'h00) | bcd(h);
        end
        return bcd(($urandom % 2) ? 23 : $urandom % 24);
      end
      4'd3: return bcd(1 + $urandom % 7);
      4'd4: return bcd(($urandom % 2) ? 28 : 1 + $urandom % 28);
      4'd5: begin
        case ($urandom % 7)
          0: return 8'h01; 1: return 8'h03; 2: return 8'h05; 3: return 8'h07;
          4: return 8'h08; 5: return 8'h10; default: return 8'h12;
        endcase
      end
      4'd6: return bcd(($urandom % 2) ? 99 : $urandom % 100);
      4'd10: return ($urandom % 4 != 0) ? 8'h01 : 8'h00;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst_n = 0; tick = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) step();

    // R1 reset contents, including unmapped addresses
    for (int a = 0; a < 16; a++) begin
      logic [7:0] e;
      case (a)
        3, 4, 5: e = 8'h01;
        9:       e = 8'h3F;
        default: e = 8'h00;
      endcase
      expect_reg(4'(a), e, "R1");
    end
    expect_alarm(1'b0, "R1");

    // R2 write masks and ignored addresses
    wr(4'd0, 8'hD9, 0); expect_reg(4'd0, 8'h59, "R2");
    wr(4'd2, 8'h52, 0); expect_reg(4'd2, 8'h12, "R2");
    wr(4'd12, 8'hFF, 0); expect_reg(4'd12, 8'h00, "R2");

    // R3 R4 R6: 24-hour midnight, plain February
    load_time(8'h23, 8'h59, 8'h59, 8'h07, 8'h28, 8'h02, 8'h23);
    ticks(1);
    expect_reg(4'd0, 8'h00, "R3");
    expect_reg(4'd1, 8'h00, "R3");
    expect_reg(4'd2, 8'h00, "R4");
    expect_reg(4'd3, 8'h01, "R6");
    expect_reg(4'd4, 8'h01, "R6");
    expect_reg(4'd5, 8'h03, "R6");

    // R6 leap February
    load_time(8'h23, 8'h59, 8'h59, 8'h03, 8'h28, 8'h02, 8'h24);
    ticks(1);
    expect_reg(4'd4, 8'h29, "R6");
    expect_reg(4'd5, 8'h02, "R6");

    // R6 thirty-day month
    load_time(8'h23, 8'h59, 8'h59, 8'h03, 8'h30, 8'h04, 8'h24);
    ticks(1);
    expect_reg(4'd4, 8'h01, "R6");
    expect_reg(4'd5, 8'h05, "R6");

    // R6 year 99 to 00
    load_time(8'h23, 8'h59, 8'h59, 8'h05, 8'h31, 8'h12, 8'h99);
    ticks(1);
    expect_reg(4'd6, 8'h00, "R6");
    expect_reg(4'd5, 8'h01, "R6");
    expect_reg(4'd4, 8'h01, "R6");

    // R5 12-hour transitions
    load_time(8'h91, 8'h59, 8'h59, 8'h02, 8'h10, 8'h06, 8'h25);
    ticks(1);
    expect_reg(4'd2, 8'hB2, "R5");
    wr(4'd1, 8'h59, 0); wr(4'd0, 8'h59, 0);
    ticks(1);
    expect_reg(4'd2, 8'hA1, "R5");
    wr(4'd2, 8'hB1, 0); wr(4'd1, 8'h59, 0); wr(4'd0, 8'h59, 0);
    ticks(1);
    expect_reg(4'd2, 8'h92, "R5");
    expect_reg(4'd4, 8'h11, "R5");

    // R7 stopped clock ignores ticks, still loads
    wr(4'd10, 8'h00, 0);
    wr(4'd0, 8'h17, 0);
    ticks(5);
    expect_reg(4'd0, 8'h17, "R7");
    expect_reg(4'd10, 8'h00, "R7");

    // R9 write wins over a coincident tick
    wr(4'd10, 8'h01, 0);
    wr(4'd0, 8'h05, 1);
    expect_reg(4'd0, 8'h05, "R9");
    wr(4'd8, 8'h33, 1);
    expect_reg(4'd0, 8'h05, "R9");

    // R8 alarm match window
    load_time(8'h10, 8'h20, 8'h30, 8'h01, 8'h05, 8'h05, 8'h25);
    wr(4'd7, 8'h32, 0); wr(4'd8, 8'h20, 0); wr(4'd9, 8'h10, 0);
    expect_alarm(1'b0, "R8");
    ticks(2);
    expect_alarm(1'b1, "R8");
    ticks(1);
    expect_alarm(1'b0, "R8");

    // Random phase against the model on every clock (R2 R3 R4 R5 R6 R7 R8 R9)
    for (int i = 0; i < 30000; i++) begin
      tick = (($urandom % 4) != 0);
      wr_en = 0;
      if (($urandom % 12) == 0) begin
        logic [3:0] a;
        a = 4'($urandom % 16);
        if (a == 4'd6 && m_mon == 2) a = 4'd0;
        wr_en = 1; wr_addr = a;
        if (a == 4'd7 && ($urandom % 2)) wr_data = bcd((m_sec + 2) % 60);
        else if (a == 4'd8 && ($urandom % 2)) wr_data = bcd(m_min);
        else if (a == 4'd9 && ($urandom % 2)) wr_data = hour_byte();
        else wr_data = rand_val(a);
      end
      step();
    end
    wr_en = 0; tick = 0;
    step();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule